// File: doc/BRIEF.md
# Interrupt Mask and Pending Register Pair

This block holds the two registers a processor core uses to control its external interrupt lines: an enable (mask) register and a pending (status) register, each one bit per line. The core reaches both through its special-purpose register port, addressed as a group number in the upper address bits and a register number in the lower eleven bits. Group 9, number 0 selects the mask and group 9, number 2 selects the pending register.

A pending bit is set by a high level on its line at a clock edge. It stays set until software clears it. Software clears a pending bit by writing a one to that bit position. Software enables lines by writing ones into the mask. A mask write merges the new ones with the old value, so no bit is ever turned off through this port. The single request to the core is high whenever any pending bit has its mask bit set. Choosing which line to serve, and in what order, is left to software.

Top module: `irq_mask_status`

## Requirements
- R1: While and after reset, the mask and the pending register both read 0 and `irqReq` is low.
- R2: A write to address (9<<11)+0 ORs `sprWdata` into the mask on the next clock edge. No mask bit is ever cleared by a write.
- R3: A write to address (9<<11)+2 clears each pending bit whose `sprWdata` bit is 1. Pending bits written with 0 keep their value.
- R4: A pending bit becomes 1 at a clock edge where its `irqLines` bit is 1. It stays 1 after the line returns to 0.
- R5: If a line is high in the same cycle as a write that clears its pending bit, the bit remains 1.
- R6: `irqReq` is 1 exactly when some bit is 1 in both the pending register and the mask. It follows register changes after the clock edge, with no additional delay.
- R7: With `sprRe` high, `sprRdata` shows the mask at number 0 or the pending register at number 2, in the same cycle. A read changes neither register.
- R8: An access to any other address leaves both registers unchanged, drives `sprHit` low and returns 0 on `sprRdata`. `sprHit` is 1 only for the two decoded addresses.
- R9: Decoding compares the group field in address bits [15:11] as well as the number field in bits [10:0]. Number 0 in any group other than 9 is not decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 32 | Level-sensitive interrupt lines, bit n sets pending bit n |
| sprWe | input | 1 | Register write strobe |
| sprRe | input | 1 | Register read strobe |
| sprAddr | input | 16 | Register address: group in [15:11], number in [10:0] |
| sprWdata | input | 32 | Write data |
| sprRdata | output | 32 | Read data, valid in the cycle `sprRe` is high |
| sprHit | output | 1 | Address is one of the two registers of this block |
| irqReq | output | 1 | Interrupt request to the core |

## Verification
The mask is written with two patterns that do not overlap and then with zero. The result shows whether writes merge or replace. Pending bits are raised by single-cycle line pulses and then cleared with data that has both ones and zeros. This separates write-one-to-clear from a plain overwrite. One clear is issued while its line is still high, which shows whether the set or the clear takes priority. The request is checked with a pending bit outside the mask and then one inside it. Accesses to a neighbouring number and to the same number in other groups show whether decoding is partial.

// File: rtl/irq_mask_status_pkg.sv
package irq_mask_status_pkg;

  // Strobes from address decode to the register datapath
  typedef struct packed {
    logic maskSet;   // merge write data into mask
    logic pendClr;   // clear pending bits written as one
    logic rdMask;    // drive mask onto read bus
    logic rdPend;    // drive pending onto read bus
  } picStrobe_t;

  function automatic logic [15:0] sprIndex(input int unsigned grp, input int unsigned num,
                                           input int unsigned numW);
    sprIndex = 16'((grp << numW) + num);
  endfunction

endpackage

// File: rtl/irq_mask_status_ctrl.sv
module irq_mask_status_ctrl
  import irq_mask_status_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_W    = 11,
  parameter int GROUP    = 9,
  parameter int MASK_NUM = 0,
  parameter int PEND_NUM = 2
) (
  input  logic              sprWe,
  input  logic              sprRe,
  input  logic [ADDR_W-1:0] sprAddr,
  output picStrobe_t        strobe,
  output logic              hit
);

  localparam int GRP_W = ADDR_W - NUM_W;
  localparam logic [GRP_W-1:0] GROUP_CODE = GRP_W'(GROUP);
  localparam logic [NUM_W-1:0] MASK_CODE  = NUM_W'(MASK_NUM);
  localparam logic [NUM_W-1:0] PEND_CODE  = NUM_W'(PEND_NUM);

  logic groupMatch;
  logic isMask;
  logic isPend;

  always_comb begin
    groupMatch = (sprAddr[ADDR_W-1:NUM_W] == GROUP_CODE);
    isMask     = groupMatch && (sprAddr[NUM_W-1:0] == MASK_CODE);
    isPend     = groupMatch && (sprAddr[NUM_W-1:0] == PEND_CODE);
    hit        = isMask || isPend;

    strobe.maskSet = sprWe && isMask;
    strobe.pendClr = sprWe && isPend;
    strobe.rdMask  = sprRe && isMask;
    strobe.rdPend  = sprRe && isPend;
  end

endmodule

// File: rtl/irq_mask_status_dp.sv
module irq_mask_status_dp
  import irq_mask_status_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  picStrobe_t        strobe,
  input  logic [DATA_W-1:0] irqLines,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] maskQ,
  output logic [DATA_W-1:0] pendQ,
  output logic              irqReq
);

  // Mask: bits only ever accumulate
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (strobe.maskSet) begin
      maskQ <= maskQ | wrData;
    end
  end

  // Pending: one cell per line, set has priority over clear
  for (genvar b = 0; b < DATA_W; b++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ[b] <= 1'b0;
      end else if (irqLines[b]) begin
        pendQ[b] <= 1'b1;
      end else if (strobe.pendClr && wrData[b]) begin
        pendQ[b] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdMask) rdData = maskQ;
    if (strobe.rdPend) rdData = pendQ;
    irqReq = |(pendQ & maskQ);
  end

endmodule

// File: rtl/irq_mask_status.sv
module irq_mask_status
  import irq_mask_status_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int NUM_W    = 11,
  parameter int GROUP    = 9,
  parameter int MASK_NUM = 0,
  parameter int PEND_NUM = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] irqLines,
  input  logic              sprWe,
  input  logic              sprRe,
  input  logic [ADDR_W-1:0] sprAddr,
  input  logic [DATA_W-1:0] sprWdata,
  output logic [DATA_W-1:0] sprRdata,
  output logic              sprHit,
  output logic              irqReq
);

  picStrobe_t        strobe;
  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] pendQ;

  irq_mask_status_ctrl #(
    .ADDR_W(ADDR_W), .NUM_W(NUM_W), .GROUP(GROUP),
    .MASK_NUM(MASK_NUM), .PEND_NUM(PEND_NUM)
  ) i_ctrl (
    .sprWe  (sprWe),
    .sprRe  (sprRe),
    .sprAddr(sprAddr),
    .strobe (strobe),
    .hit    (sprHit)
  );

  irq_mask_status_dp #(.DATA_W(DATA_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .irqLines(irqLines),
    .wrData  (sprWdata),
    .rdData  (sprRdata),
    .maskQ   (maskQ),
    .pendQ   (pendQ),
    .irqReq  (irqReq)
  );

endmodule

// File: rtl/irq_mask_status_chk.sv
module irq_mask_status_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int NUM_W    = 11,
  parameter int GROUP    = 9,
  parameter int MASK_NUM = 0,
  parameter int PEND_NUM = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] irqLines,
  input logic              sprWe,
  input logic [ADDR_W-1:0] sprAddr,
  input logic [DATA_W-1:0] sprWdata,
  input logic              sprHit,
  input logic              irqReq,
  input logic [DATA_W-1:0] maskQ,
  input logic [DATA_W-1:0] pendQ
);

  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'((GROUP << NUM_W) + MASK_NUM);
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'((GROUP << NUM_W) + PEND_NUM);

  // R2: mask bits never drop
  p_mask_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((maskQ & $past(maskQ)) == $past(maskQ)));

  // R3: written ones clear, unless the line holds the bit
  p_pend_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sprWe && sprAddr == PEND_ADDR) |=> ((pendQ & $past(sprWdata) & ~$past(irqLines)) == '0));

  // R4/R5: an active line always leaves its bit set
  p_pend_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & $past(irqLines)) == $past(irqLines)));

  // R4: without a clear write nothing pending is lost
  p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(sprWe && sprAddr == PEND_ADDR) |=> ((pendQ & $past(pendQ)) == $past(pendQ)));

  // R6: a request needs an enabled pending bit
  p_req_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((pendQ & maskQ) != '0));

  // R8: foreign writes leave the mask alone
  p_foreign_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sprWe && sprAddr != MASK_ADDR) |=> $stable(maskQ));

  // R8/R9: hit only on the two addresses
  p_hit_r9: assert property (@(posedge clk) disable iff (!rstN)
    sprHit |-> (sprAddr == MASK_ADDR || sprAddr == PEND_ADDR));

endmodule

bind irq_mask_status irq_mask_status_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_W(NUM_W), .GROUP(GROUP),
  .MASK_NUM(MASK_NUM), .PEND_NUM(PEND_NUM)
) i_chk (
  .clk(clk), .rstN(rstN), .irqLines(irqLines), .sprWe(sprWe),
  .sprAddr(sprAddr), .sprWdata(sprWdata), .sprHit(sprHit),
  .irqReq(irqReq), .maskQ(maskQ), .pendQ(pendQ)
);

// File: tb/test_irq_mask_status.sv
module test_irq_mask_status;

  localparam logic [15:0] A_MASK = 16'h4800;  // group 9, number 0
  localparam logic [15:0] A_PEND = 16'h4802;  // group 9, number 2
  localparam logic [15:0] A_GAP  = 16'h4801;  // group 9, number 1
  localparam logic [15:0] A_G10  = 16'h5000;  // group 10, number 0
  localparam logic [15:0] A_G8   = 16'h4000;  // group 8, number 0

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqLines = '0;
  logic        sprWe = 1'b0;
  logic        sprRe = 1'b0;
  logic [15:0] sprAddr = '0;
  logic [31:0] sprWdata = '0;
  logic [31:0] sprRdata;
  logic        sprHit;
  logic        irqReq;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  irq_mask_status i_irq_mask_status (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .sprWe(sprWe), .sprRe(sprRe),
    .sprAddr(sprAddr), .sprWdata(sprWdata), .sprRdata(sprRdata),
    .sprHit(sprHit), .irqReq(irqReq)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    sprWe = 1'b1; sprAddr = a; sprWdata = d;
    @(negedge clk);
    sprWe = 1'b0; sprWdata = '0;
  endtask

  task automatic doRead(input logic [15:0] a, output logic [31:0] d, output logic h);
    @(negedge clk);
    sprRe = 1'b1; sprAddr = a;
    #1;
    d = sprRdata; h = sprHit;
    @(negedge clk);
    sprRe = 1'b0;
  endtask

  task automatic pulseLines(input logic [31:0] v);
    @(negedge clk);
    irqLines = v;
    @(negedge clk);
    irqLines = '0;
  endtask

  task automatic testReset();
    logic [31:0] d; logic h;
    check(irqReq == 1'b0, "R1 irqReq after reset", 32'(irqReq), 32'h0);
    doRead(A_MASK, d, h);
    check(d == 32'h0, "R1 mask after reset", d, 32'h0);
    doRead(A_PEND, d, h);
    check(d == 32'h0, "R1 pending after reset", d, 32'h0);
  endtask

  task automatic testMaskMerge();
    logic [31:0] d; logic h;
    doWrite(A_MASK, 32'h0000_00F0);
    doWrite(A_MASK, 32'h0000_000F);
    doRead(A_MASK, d, h);
    check(d == 32'h0000_00FF, "R2 mask ORs", d, 32'h0000_00FF);
    check(h == 1'b1, "R7 hit on mask read", 32'(h), 32'h1);
    doWrite(A_MASK, 32'h0);
    doRead(A_MASK, d, h);
    check(d == 32'h0000_00FF, "R2 zero write keeps mask", d, 32'h0000_00FF);
  endtask

  task automatic testPendSet();
    logic [31:0] d; logic h;
    pulseLines(32'h0000_0005);
    repeat (2) @(negedge clk);
    doRead(A_PEND, d, h);
    check(d == 32'h0000_0005, "R4 pending latched", d, 32'h0000_0005);
  endtask

  task automatic testPendClear();
    logic [31:0] d; logic h;
    doWrite(A_PEND, 32'h0000_0001);
    doRead(A_PEND, d, h);
    check(d == 32'h0000_0004, "R3 w1c clears written one", d, 32'h0000_0004);
    doWrite(A_PEND, 32'h0);
    doRead(A_PEND, d, h);
    check(d == 32'h0000_0004, "R3 zero write keeps pending", d, 32'h0000_0004);
  endtask

  task automatic testSetWins();
    logic [31:0] d; logic h;
    @(negedge clk);
    irqLines = 32'h0000_0004;
    doWrite(A_PEND, 32'h0000_0004);
    irqLines = '0;
    doRead(A_PEND, d, h);
    check(d == 32'h0000_0004, "R5 set beats clear", d, 32'h0000_0004);
    doWrite(A_PEND, 32'h0000_0004);
    doRead(A_PEND, d, h);
    check(d == 32'h0, "R3 clear after line drops", d, 32'h0);
  endtask

  task automatic testRequest();
    pulseLines(32'h0000_0100);
    check(irqReq == 1'b0, "R6 unmasked pending gives no request", 32'(irqReq), 32'h0);
    @(negedge clk);
    irqLines = 32'h0000_0002;
    @(posedge clk);
    #1;
    check(irqReq == 1'b1, "R6 request right after edge", 32'(irqReq), 32'h1);
    @(negedge clk);
    irqLines = '0;
    doWrite(A_PEND, 32'h0000_0002);
    check(irqReq == 1'b0, "R6 request drops after clear", 32'(irqReq), 32'h0);
    doWrite(A_PEND, 32'h0000_0100);
  endtask

  task automatic testReadNoEffect();
    logic [31:0] d; logic h;
    pulseLines(32'h8000_0010);
    doRead(A_PEND, d, h);
    doRead(A_PEND, d, h);
    check(d == 32'h8000_0010, "R7 repeated read unchanged", d, 32'h8000_0010);
    check(irqReq == 1'b1, "R7 read leaves request", 32'(irqReq), 32'h1);
    doWrite(A_PEND, 32'hFFFF_FFFF);
  endtask

  task automatic testForeign();
    logic [31:0] d; logic h;
    doWrite(A_GAP, 32'hFFFF_FFFF);
    doWrite(A_G10, 32'hFFFF_FFFF);
    doWrite(A_G8, 32'hFFFF_FFFF);
    doRead(A_MASK, d, h);
    check(d == 32'h0000_00FF, "R8 foreign writes leave mask", d, 32'h0000_00FF);
    doRead(A_GAP, d, h);
    check(h == 1'b0 && d == 32'h0, "R8 gap address no hit", d, 32'h0);
    doRead(A_G8, d, h);
    check(h == 1'b0 && d == 32'h0, "R9 other group no hit", d, 32'h0);
    doRead(A_G10, d, h);
    check(h == 1'b0, "R9 group 10 no hit", 32'(h), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMaskMerge();
    testPendSet();
    testPendClear();
    testSetWins();
    testRequest();
    testReadNoEffect();
    testForeign();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule